// File: doc/BRIEF.md
# Shared-Pin General-Purpose I/O Port

This block is a multi-bit general-purpose I/O port whose pins are shared with on-chip peripherals. Software reaches it through a small register interface. It has a per-pin direction register, a per-pin output latch, and a view of the synchronized pin levels. A direction bit of 1 makes a pin an input. Every pin comes out of reset as an input with its latch cleared. A write to the pin-level view goes to the output latch and does not drive the pin directly.

Each pin has a pair of output multiplexers. When a peripheral is enabled and asserts its own output enable for a bit, it owns that pin's data and enable, and the port's driver for that bit is disabled. When a peripheral is enabled but not driving, the port drives the pin from its direction and latch bits. Pin inputs pass through a two-flop synchronizer. The synchronized levels feed both the register read path and the peripheral input bus. A peripheral input bit is forced to 0 whenever the port itself drives that pin, so the port's own output never loops back into the peripheral. A parameter mask marks the implemented bits. Masked-out bits read 0, ignore writes and never drive.

Top module: `gpio_shared_port`

## Requirements
- R1: Reset is synchronous and active high. After reset, the direction bits of all implemented pins read 1, the latch reads 0, `pin_oe` is all zeros and `rd_data` is 0.
- R2: A write strobe with `reg_sel`=0 (direction) stores `wr_data` into the direction register. `rd_data` returns the register one clock after `reg_sel`=0 is presented.
- R3: A write strobe with `reg_sel`=1 (latch) stores `wr_data` into the output latch. A read with `reg_sel`=1 returns the latch contents one clock later.
- R4: A write strobe with `reg_sel`=2 (pins) updates the output latch, which can then be read back through `reg_sel`=1. The write neither drives a pin nor changes the pin-level read.
- R5: A read with `reg_sel`=2 returns the pin levels through two synchronizer flops plus the registered read stage. A change on `pin_in` shows in `rd_data` after the third rising edge and not before.
- R6: On a bit with no active peripheral, `pin_oe` is the inverse of the direction bit and `pin_out` equals the latch bit.
- R7: On a bit where `periph_en` and `periph_oe` are both 1, `pin_oe` is 1 and `pin_out` equals `periph_out`, whatever the direction and latch bits hold. The pin level is still readable through `reg_sel`=2.
- R8: On a bit where `periph_en` is 1 and `periph_oe` is 0, the port drives the pin from its direction and latch bits, as in R6.
- R9: On a bit that is 0 in `IMPL_MASK`, the direction, latch and pin reads all return 0, writes have no effect, and `pin_oe` and `pin_out` stay 0.
- R10: `periph_in` carries the synchronized pin level. It is forced to 0 on any bit where `periph_en` is 1, `periph_oe` is 0 and the direction bit is 0.
- R11: `reg_sel`=3 is reserved. It reads as 0, and a write strobe with it changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 direction, 1 latch, 2 pins, 3 reserved |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Registered read data for the register selected in the previous cycle |
| periph_en | input | WIDTH | Per-bit enable of the peripheral sharing the pin |
| periph_oe | input | WIDTH | Per-bit peripheral output enable |
| periph_out | input | WIDTH | Per-bit peripheral output data |
| periph_in | output | WIDTH | Synchronized pin level to the peripheral, with loop-through gated |
| pin_in | input | WIDTH | Raw pad input levels |
| pin_out | output | WIDTH | Pad output data |
| pin_oe | output | WIDTH | Pad output enable, 1 drives |

## Verification
The bench builds the port with WIDTH=8 and IMPL_MASK=8'h7D, which leaves bits 1 and 7 unimplemented. Every register and drive check therefore also sees holes in the mask. The peripheral patterns mix enabled-driving, enabled-idle and disabled bits in one word, so ownership, fallback to the port and loop-through gating are each observed on separate bits in the same cycle. The pin-read test samples both before and after the third edge, which pins down the synchronizer latency.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    SEL_DIR   = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_PINS  = 2'd2,
    SEL_RSVD  = 2'd3
  } port_sel_e;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int              WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       reg_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] lat_q
);
  import gpio_port_pkg::*;

  logic dir_we;
  logic lat_we;

  always_comb begin
    dir_we = wr_en && (port_sel_e'(reg_sel) == SEL_DIR);
    lat_we = wr_en && ((port_sel_e'(reg_sel) == SEL_LATCH) ||
                       (port_sel_e'(reg_sel) == SEL_PINS));
  end

  // Direction: 1 = input; implemented bits wake up as inputs
  always_ff @(posedge clk) begin
    if (rst)         dir_q <= IMPL_MASK;
    else if (dir_we) dir_q <= wr_data & IMPL_MASK;
  end

  // Output latch, shared target of latch and pin-view writes
  always_ff @(posedge clk) begin
    if (rst)         lat_q <= '0;
    else if (lat_we) lat_q <= wr_data & IMPL_MASK;
  end

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_port_pinmux.sv
module gpio_port_pinmux #(
  parameter int              WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] lat_q,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] periph_en,
  input  logic [WIDTH-1:0] periph_oe,
  input  logic [WIDTH-1:0] periph_out,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] periph_in
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_impl
      logic periph_owns;
      logic port_drives;
      always_comb begin
        periph_owns  = periph_en[b] & periph_oe[b];
        port_drives  = ~periph_owns & ~dir_q[b];
        pin_oe[b]    = periph_owns | port_drives;
        pin_out[b]   = periph_owns ? periph_out[b] : lat_q[b];
        // block the port's own drive from reaching the peripheral
        periph_in[b] = pin_sync[b] & ~(periph_en[b] & port_drives);
      end
    end else begin : g_absent
      assign pin_oe[b]    = 1'b0;
      assign pin_out[b]   = 1'b0;
      assign periph_in[b] = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port #(
  parameter int              WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = '1,
  parameter int              SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       reg_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] periph_en,
  input  logic [WIDTH-1:0] periph_oe,
  input  logic [WIDTH-1:0] periph_out,
  output logic [WIDTH-1:0] periph_in,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  import gpio_port_pkg::*;

  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] pin_sync_raw;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] rd_next;

  gpio_port_regs #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .reg_sel (reg_sel),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .dir_q   (dir_q),
    .lat_q   (lat_q)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync_raw)
  );

  assign pin_sync = pin_sync_raw & IMPL_MASK;

  gpio_port_pinmux #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_mux (
    .dir_q      (dir_q),
    .lat_q      (lat_q),
    .pin_sync   (pin_sync),
    .periph_en  (periph_en),
    .periph_oe  (periph_oe),
    .periph_out (periph_out),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .periph_in  (periph_in)
  );

  always_comb begin
    unique case (port_sel_e'(reg_sel))
      SEL_DIR:   rd_next = dir_q;
      SEL_LATCH: rd_next = lat_q;
      SEL_PINS:  rd_next = pin_sync;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

endmodule

// File: rtl/gpio_shared_port_chk.sv
module gpio_shared_port_chk #(
  parameter int              WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       reg_sel,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] periph_en,
  input logic [WIDTH-1:0] periph_oe,
  input logic [WIDTH-1:0] periph_out,
  input logic [WIDTH-1:0] periph_in,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] lat_q
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (dir_q == IMPL_MASK && lat_q == '0 && rd_data == '0));

  a_r2_dir_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 2'd0) |=> (dir_q == ($past(wr_data) & IMPL_MASK)));

  a_r3_lat_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 2'd1) |=> (lat_q == ($past(wr_data) & IMPL_MASK)));

  a_r4_pins_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 2'd2) |=> (lat_q == ($past(wr_data) & IMPL_MASK)));

  a_r7_override: assert property (@(posedge clk) disable iff (rst)
    (((periph_en & periph_oe & IMPL_MASK) & ~pin_oe) == '0) &&
    (((pin_out ^ periph_out) & periph_en & periph_oe & IMPL_MASK) == '0));

  a_r9_unimpl: assert property (@(posedge clk) disable iff (rst)
    ((pin_oe | pin_out | rd_data | periph_in) & ~IMPL_MASK) == '0);

  a_r10_no_loop: assert property (@(posedge clk) disable iff (rst)
    (periph_in & pin_oe & periph_en & ~periph_oe) == '0);

  a_r5_sync_path: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |->
      ((periph_in & ~periph_en) == ($past(pin_in, 2) & ~periph_en & IMPL_MASK)));

  a_r11_reserved: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 2'd3) |=> ($stable(dir_q) && $stable(lat_q)));

endmodule

bind gpio_shared_port gpio_shared_port_chk #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .periph_en(periph_en), .periph_oe(periph_oe),
  .periph_out(periph_out), .periph_in(periph_in), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .dir_q(dir_q), .lat_q(lat_q)
);

// File: tb/gpio_shared_port_tb.sv
module gpio_shared_port_tb;
  localparam int         W    = 8;
  localparam logic [7:0] MASK = 8'h7D;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   reg_sel = 2'd0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [W-1:0] periph_en = '0, periph_oe = '0, periph_out = '0;
  logic [W-1:0] periph_in;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_shared_port #(.WIDTH(W), .IMPL_MASK(MASK)) u_dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .periph_en(periph_en), .periph_oe(periph_oe),
    .periph_out(periph_out), .periph_in(periph_in), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [W-1:0] d);
    @(negedge clk);
    reg_sel = sel; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [W-1:0] v);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    chk("R1", "rd_data in reset", rd_data, 8'h00);
    chk("R1", "pin_oe in reset", pin_oe, 8'h00);
    rst = 1'b0;
    rd(2'd0, v); chk("R1", "dir after reset", v, MASK);
    rd(2'd1, v); chk("R1", "latch after reset", v, 8'h00);
  endtask

  task automatic t_regs;
    logic [W-1:0] v;
    wr(2'd0, 8'h0F); rd(2'd0, v); chk("R2", "dir readback masked (R9)", v, 8'h0D);
    wr(2'd1, 8'hA5); rd(2'd1, v); chk("R3", "latch readback masked (R9)", v, 8'h25);
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h3C); rd(2'd1, v); chk("R4", "pins write lands in latch", v, 8'h3C);
    chk("R4", "pins write does not drive", pin_oe, 8'h00);
    rd(2'd2, v); chk("R4", "pin view unchanged by write", v, 8'h00);
  endtask

  task automatic t_pin_read;
    @(negedge clk);
    reg_sel = 2'd2; pin_in = 8'hFF;
    repeat (2) @(negedge clk);
    chk("R5", "pin read before third edge", rd_data, 8'h00);
    @(negedge clk);
    chk("R5", "pin read after third edge (R9 mask)", rd_data, MASK);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_drive;
    wr(2'd1, 8'h55);
    wr(2'd0, 8'h00);
    chk("R6", "all outputs enabled", pin_oe, MASK);
    chk("R6", "pin_out follows latch", pin_out, 8'h55);
    wr(2'd0, 8'hF0);
    chk("R6", "partial direction", pin_oe, 8'h0D);
  endtask

  task automatic t_override;
    logic [W-1:0] v;
    wr(2'd0, 8'hFF);
    @(negedge clk);
    periph_en = 8'h0F; periph_oe = 8'h05; periph_out = 8'h04;
    #1;
    chk("R7", "peripheral enables", pin_oe, 8'h05);
    chk("R7", "peripheral data", pin_out & pin_oe, 8'h04);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h00);
    chk("R8", "idle peripheral bits fall to port", pin_oe, MASK);
    chk("R8", "mixed data", pin_out, 8'h7C);
    pin_in = 8'hAA;
    repeat (3) @(negedge clk);
    rd(2'd2, v); chk("R7", "pin readable under override", v, 8'h28);
  endtask

  task automatic t_loop;
    @(negedge clk);
    pin_in = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R10", "port-owned bit gated", periph_in, 8'h75);
    wr(2'd0, 8'hFF);
    chk("R10", "input bits pass", periph_in, MASK);
    @(negedge clk);
    periph_en = '0; periph_oe = '0; periph_out = '0;
  endtask

  task automatic t_reserved;
    logic [W-1:0] v;
    wr(2'd0, 8'h30);
    wr(2'd1, 8'h41);
    wr(2'd3, 8'hFF);
    rd(2'd0, v); chk("R11", "dir untouched", v, 8'h30);
    rd(2'd1, v); chk("R11", "latch untouched", v, 8'h41);
    rd(2'd3, v); chk("R11", "reserved reads zero", v, 8'h00);
    wr(2'd0, 8'h82); rd(2'd0, v); chk("R9", "unimplemented dir bits", v, 8'h00);
  endtask

  initial begin
    t_reset;
    t_regs;
    t_pin_read;
    t_drive;
    t_override;
    t_loop;
    t_reserved;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule